// File: doc/BRIEF.md
# Link Source Ingress Buffer with Merged Full Flag

This block sits at the sending end of a point-to-point data link. A front-end board hands it 64-bit words, each with a marker bit. The block stores the words in a FIFO so that a slower transmit path can drain them at its own pace. The transmit side takes words over a valid/ready handshake.

The block drives a single active-low full flag back to the writer. Two conditions pull the flag low. The first is a pause request that arrives from the far end of the link. The second is the local FIFO running short of room. Once the flag is low, the writer may go on for up to 16 more clock cycles. The FIFO keeps enough headroom that those late words are never lost.

The flag goes high again only when two things are true: the far end has sent a resume, and the FIFO has drained well below the level that set the flag. A width-select input must carry the native 64-bit code. Any other code raises a configuration error and stops all writes.

Top module: `lsc_ingress_buf`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `full_n` is 1, `tx_valid` is 0, `cfg_err` is 0 and `drop_cnt` is 0.
- R2: A word is captured on a rising edge of `clk` when `wr_en_n` is 0. A `wr_ctrl_n` of 0 marks the word, and the mark appears as `tx_ctrl` = 1. Words leave on `tx_data` in the order they were written.
- R3: A cycle with `xoff_rx` = 1 drives `full_n` to 0 at the next edge. If `xoff_rx` and `xon_rx` are both 1 in the same cycle, the pause request wins.
- R4: Free space is DEPTH (64) minus the number of words held in the memory. The word waiting on the `tx_*` outputs does not count. Whenever free space after an edge is 16 or less, `full_n` is 0. The 16 writes that follow the fall of `full_n` are all kept.
- R5: `full_n` returns to 1 only when no pause request is pending and free space is greater than 32. Between those limits the flag keeps its last value.
- R6: A write that arrives while the memory holds 64 words is discarded. Each such write adds one to `drop_cnt`.
- R7: A `width_sel` code other than 2'b11 sets `cfg_err` at the next edge. While `cfg_err` is 1, writes are ignored and are not counted as drops. The code 2'b11 clears `cfg_err` at the next edge.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` and `tx_ctrl` hold steady. A word is consumed on an edge where both `tx_valid` and `tx_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the write port is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| width_sel | input | 2 | Data-width code; only 2'b11 (64-bit) is accepted |
| wr_en_n | input | 1 | Write strobe, active low |
| wr_ctrl_n | input | 1 | Word marker, active low |
| wr_data | input | 64 | Word from the front-end board |
| full_n | output | 1 | Merged full flag, active low |
| cfg_err | output | 1 | Unsupported width code seen |
| drop_cnt | output | 16 | Count of words discarded because the memory was full (saturates) |
| xoff_rx | input | 1 | One-cycle pulse: pause request received from the far end |
| xon_rx | input | 1 | One-cycle pulse: resume received from the far end |
| tx_valid | output | 1 | A word is available to the transmit path |
| tx_ready | input | 1 | The transmit path accepts the word |
| tx_data | output | 64 | Word to transmit |
| tx_ctrl | output | 1 | Marker of the word to transmit, active high |

## Verification
The assertions watch several rules on every cycle:
- the flag falls one edge after a pause request;
- the flag is low whenever free space is 16 or less;
- every rise of the flag happens with more than 32 words free;
- the drop count moves only after a write into a full memory;
- memory fill never grows while `cfg_err` is set;
- a stalled output word holds steady.

Some properties span many cycles, and only the bench scenarios can show them:
- the exact write count at which the flag falls;
- the 16 late writes all surviving;
- the word order after a long drain;
- the hysteresis window when a remote pause and a local fill overlap.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  // Width code that selects native 64-bit operation
  localparam logic [1:0] WIDTH_NATIVE = 2'b11;

  // Full flag state: open accepts words, held asks the writer to stop
  typedef enum logic {FLG_OPEN = 1'b0, FLG_HELD = 1'b1} flag_state_t;
endpackage

// File: rtl/lsc_word_store.sv
module lsc_word_store #(
  parameter int DW    = 64,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW:0]   push_word,
  output logic          rejected,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW:0]   out_word,
  output logic [CW-1:0] level,
  output logic [CW-1:0] level_next
);
  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          wr_ok, pop, mem_full;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign mem_full   = (level == CW'(DEPTH));
  assign wr_ok      = push && !mem_full;
  assign rejected   = push && mem_full;
  assign pop        = (level != '0) && (!out_valid || out_ready);
  assign level_next = level + CW'(wr_ok) - CW'(pop);

  // Storage array: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= push_word;
  end

  // Synchronous read straight into the output register
  always_ff @(posedge clk) begin
    if (pop) out_word <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level     <= '0;
      out_valid <= 1'b0;
    end else begin
      level <= level_next;
      if (wr_ok) wr_ptr <= bump(wr_ptr);
      if (pop) begin
        rd_ptr    <= bump(rd_ptr);
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lsc_flag_ctrl.sv
module lsc_flag_ctrl
  import lsc_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int HEADROOM = 16,
  parameter int RELEASE  = 32,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xoff_pulse,
  input  logic          xon_pulse,
  input  logic [CW-1:0] level_next,
  output logic          full_n
);
  flag_state_t   state_q, state_d;
  logic          hold_q, hold_d;
  logic [CW-1:0] free_next;

  assign free_next = CW'(DEPTH) - level_next;

  always_comb begin
    // a pause request outranks a resume seen in the same cycle
    hold_d = xoff_pulse ? 1'b1 : (xon_pulse ? 1'b0 : hold_q);
    state_d = state_q;
    case (state_q)
      FLG_OPEN: if (hold_d || free_next <= CW'(HEADROOM)) state_d = FLG_HELD;
      FLG_HELD: if (!hold_d && free_next > CW'(RELEASE))  state_d = FLG_OPEN;
      default:  state_d = FLG_HELD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b0;
      state_q <= FLG_OPEN;
    end else begin
      hold_q  <= hold_d;
      state_q <= state_d;
    end
  end

  assign full_n = (state_q == FLG_OPEN);
endmodule

// File: rtl/lsc_cfg_guard.sv
module lsc_cfg_guard
  import lsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] width_sel,
  output logic       cfg_err
);
  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= (width_sel != WIDTH_NATIVE);
  end
endmodule

// File: rtl/lsc_drop_count.sv
module lsc_drop_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (inc && ~&cnt)    cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/lsc_ingress_buf.sv
module lsc_ingress_buf #(
  parameter int DW       = 64,
  parameter int DEPTH    = 64,
  parameter int HEADROOM = 16,
  parameter int RELEASE  = 32,
  parameter int DROP_W   = 16,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        width_sel,
  input  logic              wr_en_n,
  input  logic              wr_ctrl_n,
  input  logic [DW-1:0]     wr_data,
  output logic              full_n,
  output logic              cfg_err,
  output logic [DROP_W-1:0] drop_cnt,
  input  logic              xoff_rx,
  input  logic              xon_rx,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DW-1:0]     tx_data,
  output logic              tx_ctrl
);
  logic          push, rejected;
  logic [DW:0]   out_word;
  logic [CW-1:0] level, level_next, free_now;

  assign push     = !wr_en_n && !cfg_err;
  assign free_now = CW'(DEPTH) - level;
  assign tx_ctrl  = out_word[DW];
  assign tx_data  = out_word[DW-1:0];

  lsc_cfg_guard u_cfg (
    .clk(clk), .rst(rst), .width_sel(width_sel), .cfg_err(cfg_err)
  );

  lsc_word_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push(push), .push_word({~wr_ctrl_n, wr_data}),
    .rejected(rejected), .out_valid(tx_valid), .out_ready(tx_ready),
    .out_word(out_word), .level(level), .level_next(level_next)
  );

  lsc_flag_ctrl #(.DEPTH(DEPTH), .HEADROOM(HEADROOM), .RELEASE(RELEASE)) u_flag (
    .clk(clk), .rst(rst), .xoff_pulse(xoff_rx), .xon_pulse(xon_rx),
    .level_next(level_next), .full_n(full_n)
  );

  lsc_drop_count #(.W(DROP_W)) u_drop (
    .clk(clk), .rst(rst), .inc(rejected), .cnt(drop_cnt)
  );
endmodule

// File: rtl/lsc_ingress_buf_chk.sv
module lsc_ingress_buf_chk #(
  parameter int DW       = 64,
  parameter int DEPTH    = 64,
  parameter int HEADROOM = 16,
  parameter int RELEASE  = 32,
  parameter int DROP_W   = 16,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_n,
  input logic              full_n,
  input logic              cfg_err,
  input logic [DROP_W-1:0] drop_cnt,
  input logic              xoff_rx,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DW-1:0]     tx_data,
  input logic              tx_ctrl,
  input logic [CW-1:0]     free_now
);
  p_pause_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
    xoff_rx |=> !full_n);

  p_low_space_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (free_now <= CW'(HEADROOM)) |-> !full_n);

  p_release_margin_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(full_n) |-> (free_now > CW'(RELEASE)));

  p_drop_only_full_r6: assert property (@(posedge clk) disable iff (rst)
    (drop_cnt != $past(drop_cnt)) |-> $past(free_now == '0 && !wr_en_n && !cfg_err));

  p_cfg_blocks_fill_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> (free_now >= $past(free_now)));

  p_stall_holds_word_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_ctrl)));
endmodule

bind lsc_ingress_buf lsc_ingress_buf_chk #(
  .DW(DW), .DEPTH(DEPTH), .HEADROOM(HEADROOM), .RELEASE(RELEASE), .DROP_W(DROP_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .full_n(full_n), .cfg_err(cfg_err),
  .drop_cnt(drop_cnt), .xoff_rx(xoff_rx), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_ctrl(tx_ctrl), .free_now(free_now)
);

// File: tb/lsc_ingress_buf_test.sv
module lsc_ingress_buf_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  width_sel = 2'b11;
  logic        wr_en_n = 1'b1;
  logic        wr_ctrl_n = 1'b1;
  logic [63:0] wr_data = '0;
  logic        full_n, cfg_err, tx_valid, tx_ctrl;
  logic [15:0] drop_cnt;
  logic        xoff_rx = 1'b0, xon_rx = 1'b0, tx_ready = 1'b0;
  logic [63:0] tx_data;

  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lsc_ingress_buf uut (
    .clk(clk), .rst(rst), .width_sel(width_sel), .wr_en_n(wr_en_n),
    .wr_ctrl_n(wr_ctrl_n), .wr_data(wr_data), .full_n(full_n), .cfg_err(cfg_err),
    .drop_cnt(drop_cnt), .xoff_rx(xoff_rx), .xon_rx(xon_rx), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_ctrl(tx_ctrl)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en_n = 1'b1; xoff_rx = 1'b0; xon_rx = 1'b0;
    tx_ready = 1'b0; width_sel = 2'b11;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic put(input logic [63:0] d, input bit mark);
    wr_data = d; wr_ctrl_n = !mark; wr_en_n = 1'b0;
    @(negedge clk);
    wr_en_n = 1'b1;
  endtask

  task automatic take();
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic pulse(input bit off, input bit on);
    xoff_rx = off; xon_rx = on;
    @(negedge clk);
    xoff_rx = 1'b0; xon_rx = 1'b0;
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    @(negedge clk);
    check(full_n == 1'b1, "R1", "full_n in reset", full_n, 1);
    check(tx_valid == 1'b0, "R1", "tx_valid in reset", tx_valid, 0);
    check(cfg_err == 1'b0, "R1", "cfg_err in reset", cfg_err, 0);
    check(drop_cnt == 16'd0, "R1", "drop_cnt in reset", drop_cnt, 0);
    do_reset();
    check(full_n == 1'b1 && tx_valid == 1'b0, "R1", "state after reset",
          {full_n, tx_valid}, 2'b10);
  endtask

  task automatic t_order_and_mark();
    do_reset();
    put(64'hA1, 1'b0);
    put(64'hB2, 1'b1);
    put(64'hC3, 1'b0);
    check(tx_valid && tx_data == 64'hA1, "R2", "first word", tx_data, 64'hA1);
    check(tx_ctrl == 1'b0, "R2", "first mark", tx_ctrl, 0);
    @(negedge clk);
    check(tx_valid && tx_data == 64'hA1, "R8", "word held while stalled", tx_data, 64'hA1);
    take();
    check(tx_data == 64'hB2 && tx_ctrl == 1'b1, "R2", "second word marked",
          {tx_ctrl, tx_data[7:0]}, 9'h1B2);
    take();
    check(tx_data == 64'hC3 && tx_ctrl == 1'b0, "R2", "third word", tx_data, 64'hC3);
    take();
    check(tx_valid == 1'b0, "R8", "empty after three takes", tx_valid, 0);
  endtask

  task automatic t_fill_and_drain();
    do_reset();
    // first word moves to the output register; memory then holds writes-1
    for (int i = 1; i <= 48; i++) put(64'(i), 1'b0);
    check(full_n == 1'b1, "R4", "flag with 17 free", full_n, 1);
    put(64'd49, 1'b0);
    check(full_n == 1'b0, "R4", "flag with 16 free", full_n, 0);
    for (int i = 50; i <= 65; i++) put(64'(i), 1'b0);
    check(drop_cnt == 16'd0, "R4", "16 late writes kept", drop_cnt, 0);
    put(64'd66, 1'b0);
    check(drop_cnt == 16'd1, "R6", "write into full memory dropped", drop_cnt, 1);
    for (int i = 0; i < 32; i++) take();
    check(full_n == 1'b0, "R5", "flag held with 32 free", full_n, 1'b0);
    take();
    check(full_n == 1'b1, "R5", "flag released with 33 free", full_n, 1);
    check(tx_data == 64'd34, "R4", "order after drain", tx_data, 34);
    check(drop_cnt == 16'd1, "R6", "no drop while draining", drop_cnt, 1);
  endtask

  task automatic t_remote_pause();
    do_reset();
    pulse(1'b1, 1'b0);
    check(full_n == 1'b0, "R3", "pause request sets flag", full_n, 0);
    repeat (3) @(negedge clk);
    check(full_n == 1'b0, "R3", "flag stays without resume", full_n, 0);
    pulse(1'b0, 1'b1);
    check(full_n == 1'b1, "R5", "resume with empty buffer", full_n, 1);
    pulse(1'b1, 1'b1);
    check(full_n == 1'b0, "R3", "pause beats resume", full_n, 0);
    pulse(1'b0, 1'b1);
    check(full_n == 1'b1, "R5", "resume after tie", full_n, 1);
  endtask

  task automatic t_merged_hysteresis();
    do_reset();
    for (int i = 1; i <= 41; i++) put(64'(i), 1'b1);
    check(full_n == 1'b1, "R4", "24 free leaves flag high", full_n, 1);
    pulse(1'b1, 1'b0);
    check(full_n == 1'b0, "R3", "pause over partial fill", full_n, 0);
    pulse(1'b0, 1'b1);
    check(full_n == 1'b0, "R5", "resume with 24 free keeps flag", full_n, 0);
    for (int i = 0; i < 8; i++) take();
    check(full_n == 1'b0, "R5", "32 free keeps flag", full_n, 0);
    take();
    check(full_n == 1'b1, "R5", "33 free releases flag", full_n, 1);
  endtask

  task automatic t_width_code();
    do_reset();
    width_sel = 2'b00;
    @(negedge clk);
    check(cfg_err == 1'b1, "R7", "code 00 flagged", cfg_err, 1);
    put(64'h11, 1'b0);
    put(64'h22, 1'b0);
    repeat (2) @(negedge clk);
    check(tx_valid == 1'b0, "R7", "writes ignored", tx_valid, 0);
    check(drop_cnt == 16'd0, "R7", "ignored writes not dropped", drop_cnt, 0);
    width_sel = 2'b01;
    @(negedge clk);
    check(cfg_err == 1'b1, "R7", "code 01 flagged", cfg_err, 1);
    width_sel = 2'b10;
    @(negedge clk);
    check(cfg_err == 1'b1, "R7", "code 10 flagged", cfg_err, 1);
    width_sel = 2'b11;
    @(negedge clk);
    check(cfg_err == 1'b0, "R7", "code 11 clears", cfg_err, 0);
    put(64'h77, 1'b0);
    @(negedge clk);
    check(tx_valid && tx_data == 64'h77, "R7", "write accepted again", tx_data, 64'h77);
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_order_and_mark();
    t_fill_and_drain();
    t_remote_pause();
    t_merged_hysteresis();
    t_width_code();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule